// File: doc/BRIEF.md
# Bidirectional Latched Bus Transceiver

This block connects two bus ports, A and B, and carries data between them in either direction. The bus is cut into independent byte-wide halves. Each half has three active-low controls for each direction. The path enable admits data into that direction's storage and also permits driving. The latch enable switches the storage between following its source and holding a value. The output enable switches the drivers on the destination port. Every output port is modelled as a data word plus a per-bit drive-enable, which stands in for a three-state pad.

All controls and data are registered on one system clock, so the latch is modelled synchronously. While a direction is open (path enable and latch enable both low), its storage loads the registered source every cycle and the destination shows the current source. When the latch enable goes high, the storage keeps the source value from the last cycle in which it was open. A per-half flag reports when both directions drive the same half at once. The outputs of a flagged half are still driven as commanded.

Top module: `latched_bus_xcvr`

## Requirements
- R1: After a synchronous reset (rstN low), every drive-enable bit and every contention bit is 0 and all storage holds 0. Enabling the path and output with the latch enable high then shows 0 on the destination port.
- R2: Inputs are sampled on a rising clock edge, and the outputs reflect them right after that edge. Between edges the outputs do not change when the inputs change.
- R3: All bits of half h of bDriveEn (bits h*8 to h*8+7) are 1 exactly when pathEnAbN[h] and outEnAbN[h] were both 0 at the last edge. Otherwise they are all 0.
- R4: When pathEnAbN[h] and latchEnAbN[h] are both 0, half h of bOut equals half h of aIn sampled at the same edge.
- R5: When latchEnAbN[h] goes from 0 to 1 with pathEnAbN[h] at 0, half h of bOut holds the aIn value from the last edge at which the latch enable was 0. Later changes of aIn are ignored while the latch enable stays 1.
- R6: While pathEnAbN[h] is 1, the A-to-B storage of half h is not loaded, whatever the latch enable does. This shows when the path is later enabled with the latch enable high.
- R7: The output enable has no effect on loading. A value loaded while outEnAbN[h] is 1 is the one shown once the output is enabled.
- R8: The B-to-A direction follows R3 to R7 with bIn, aOut, aDriveEn and pathEnBaN, latchEnBaN and outEnBaN.
- R9: The controls of one half have no effect on the data or drive-enables of the other half.
- R10: contention[h] is 1 exactly when half h of both aDriveEn and bDriveEn is on. Both ports still drive.
- R11: Half h occupies bits h*8 to h*8+7 of every bus port. Half 0 is the low byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| aIn | input | 16 | Data arriving on port A |
| bIn | input | 16 | Data arriving on port B |
| pathEnAbN | input | 2 | Per-half A-to-B path enable, active low |
| latchEnAbN | input | 2 | Per-half A-to-B latch enable, active low (low = transparent) |
| outEnAbN | input | 2 | Per-half port B output enable, active low |
| pathEnBaN | input | 2 | Per-half B-to-A path enable, active low |
| latchEnBaN | input | 2 | Per-half B-to-A latch enable, active low |
| outEnBaN | input | 2 | Per-half port A output enable, active low |
| aOut | output | 16 | Data driven onto port A |
| aDriveEn | output | 16 | Per-bit drive enable for port A (0 = high impedance) |
| bOut | output | 16 | Data driven onto port B |
| bDriveEn | output | 16 | Per-bit drive enable for port B (0 = high impedance) |
| contention | output | 2 | Per-half flag: both directions driving |

## Verification
The bench builds the block with its default parameters: two halves of eight bits each. With these values every control combination can be swept for each half in each direction, preceded by a known preload and followed by a probe of what the storage kept. Two halves are enough to show that they are independent and to place each byte in the word. They also allow a case where contention is flagged in one half but not the other.

// File: rtl/bxcvr_pkg.sv
package bxcvr_pkg;
  // Per-half strobes passed from control to datapath
  typedef struct packed {
    logic openAb;   // A-to-B storage transparent (load and pass through)
    logic driveAb;  // port B driven
    logic openBa;   // B-to-A storage transparent
    logic driveBa;  // port A driven
  } halfStrobe_t;
endpackage

// File: rtl/bxcvr_ctrl.sv
module bxcvr_ctrl
  import bxcvr_pkg::*;
#(
  parameter int NUM_HALVES = 2
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic [NUM_HALVES-1:0]             pathEnAbN,
  input  logic [NUM_HALVES-1:0]             latchEnAbN,
  input  logic [NUM_HALVES-1:0]             outEnAbN,
  input  logic [NUM_HALVES-1:0]             pathEnBaN,
  input  logic [NUM_HALVES-1:0]             latchEnBaN,
  input  logic [NUM_HALVES-1:0]             outEnBaN,
  output halfStrobe_t [NUM_HALVES-1:0]      strobes,
  output logic [NUM_HALVES-1:0]             contention
);
  logic [NUM_HALVES-1:0] pathAbQ, latchAbQ, outAbQ;
  logic [NUM_HALVES-1:0] pathBaQ, latchBaQ, outBaQ;

  // Controls idle high out of reset, so nothing drives and nothing loads
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pathAbQ  <= '1;
      latchAbQ <= '1;
      outAbQ   <= '1;
      pathBaQ  <= '1;
      latchBaQ <= '1;
      outBaQ   <= '1;
    end else begin
      pathAbQ  <= pathEnAbN;
      latchAbQ <= latchEnAbN;
      outAbQ   <= outEnAbN;
      pathBaQ  <= pathEnBaN;
      latchBaQ <= latchEnBaN;
      outBaQ   <= outEnBaN;
    end
  end

  for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
    always_comb begin
      strobes[h].openAb  = ~pathAbQ[h] & ~latchAbQ[h];
      strobes[h].driveAb = ~pathAbQ[h] & ~outAbQ[h];
      strobes[h].openBa  = ~pathBaQ[h] & ~latchBaQ[h];
      strobes[h].driveBa = ~pathBaQ[h] & ~outBaQ[h];
    end
    assign contention[h] = strobes[h].driveAb & strobes[h].driveBa;
  end
endmodule

// File: rtl/bxcvr_datapath.sv
module bxcvr_datapath
  import bxcvr_pkg::*;
#(
  parameter int HALF_W     = 8,
  parameter int NUM_HALVES = 2,
  localparam int BUS_W     = HALF_W * NUM_HALVES
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [BUS_W-1:0]             aIn,
  input  logic [BUS_W-1:0]             bIn,
  input  halfStrobe_t [NUM_HALVES-1:0] strobes,
  output logic [BUS_W-1:0]             aOut,
  output logic [BUS_W-1:0]             aDriveEn,
  output logic [BUS_W-1:0]             bOut,
  output logic [BUS_W-1:0]             bDriveEn
);
  logic [BUS_W-1:0] aQ, bQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      aQ <= '0;
      bQ <= '0;
    end else begin
      aQ <= aIn;
      bQ <= bIn;
    end
  end

  for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
    logic [HALF_W-1:0] abStore, baStore;

    // Storage loads only while its direction is open; holding otherwise
    always_ff @(posedge clk) begin
      if (!rstN) begin
        abStore <= '0;
        baStore <= '0;
      end else begin
        if (strobes[h].openAb) abStore <= aQ[h*HALF_W +: HALF_W];
        if (strobes[h].openBa) baStore <= bQ[h*HALF_W +: HALF_W];
      end
    end

    assign bOut[h*HALF_W +: HALF_W] = strobes[h].openAb ? aQ[h*HALF_W +: HALF_W] : abStore;
    assign aOut[h*HALF_W +: HALF_W] = strobes[h].openBa ? bQ[h*HALF_W +: HALF_W] : baStore;
    assign bDriveEn[h*HALF_W +: HALF_W] = {HALF_W{strobes[h].driveAb}};
    assign aDriveEn[h*HALF_W +: HALF_W] = {HALF_W{strobes[h].driveBa}};
  end
endmodule

// File: rtl/latched_bus_xcvr.sv
module latched_bus_xcvr
  import bxcvr_pkg::*;
#(
  parameter int HALF_W     = 8,
  parameter int NUM_HALVES = 2,
  localparam int BUS_W     = HALF_W * NUM_HALVES
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [BUS_W-1:0]      aIn,
  input  logic [BUS_W-1:0]      bIn,
  input  logic [NUM_HALVES-1:0] pathEnAbN,
  input  logic [NUM_HALVES-1:0] latchEnAbN,
  input  logic [NUM_HALVES-1:0] outEnAbN,
  input  logic [NUM_HALVES-1:0] pathEnBaN,
  input  logic [NUM_HALVES-1:0] latchEnBaN,
  input  logic [NUM_HALVES-1:0] outEnBaN,
  output logic [BUS_W-1:0]      aOut,
  output logic [BUS_W-1:0]      aDriveEn,
  output logic [BUS_W-1:0]      bOut,
  output logic [BUS_W-1:0]      bDriveEn,
  output logic [NUM_HALVES-1:0] contention
);
  halfStrobe_t [NUM_HALVES-1:0] strobes;

  bxcvr_ctrl #(.NUM_HALVES(NUM_HALVES)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .pathEnAbN  (pathEnAbN),
    .latchEnAbN (latchEnAbN),
    .outEnAbN   (outEnAbN),
    .pathEnBaN  (pathEnBaN),
    .latchEnBaN (latchEnBaN),
    .outEnBaN   (outEnBaN),
    .strobes    (strobes),
    .contention (contention)
  );

  bxcvr_datapath #(.HALF_W(HALF_W), .NUM_HALVES(NUM_HALVES)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .aIn      (aIn),
    .bIn      (bIn),
    .strobes  (strobes),
    .aOut     (aOut),
    .aDriveEn (aDriveEn),
    .bOut     (bOut),
    .bDriveEn (bDriveEn)
  );
endmodule

// File: rtl/bxcvr_checker.sv
module bxcvr_checker #(
  parameter int HALF_W     = 8,
  parameter int NUM_HALVES = 2,
  localparam int BUS_W     = HALF_W * NUM_HALVES
) (
  input logic                  clk,
  input logic                  rstN,
  input logic [BUS_W-1:0]      aIn,
  input logic [BUS_W-1:0]      bIn,
  input logic [NUM_HALVES-1:0] pathEnAbN,
  input logic [NUM_HALVES-1:0] latchEnAbN,
  input logic [NUM_HALVES-1:0] outEnAbN,
  input logic [NUM_HALVES-1:0] pathEnBaN,
  input logic [NUM_HALVES-1:0] latchEnBaN,
  input logic [NUM_HALVES-1:0] outEnBaN,
  input logic [BUS_W-1:0]      aOut,
  input logic [BUS_W-1:0]      aDriveEn,
  input logic [BUS_W-1:0]      bOut,
  input logic [BUS_W-1:0]      bDriveEn,
  input logic [NUM_HALVES-1:0] contention
);
  // Edges seen since reset was released, saturating
  logic [1:0] upCnt;
  always_ff @(posedge clk) begin
    if (!rstN) upCnt <= '0;
    else if (upCnt != 2'd3) upCnt <= upCnt + 2'd1;
  end

  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rstN)
    (upCnt == 2'd0) |-> (aDriveEn == '0 && bDriveEn == '0 && contention == '0));

  for (genvar h = 0; h < NUM_HALVES; h++) begin : g_chk
    assert_drive_b_R3: assert property (@(posedge clk) disable iff (!rstN)
      (upCnt != 2'd0) |->
        (bDriveEn[h*HALF_W +: HALF_W] == {HALF_W{~$past(pathEnAbN[h]) & ~$past(outEnAbN[h])}}));

    assert_drive_a_R8: assert property (@(posedge clk) disable iff (!rstN)
      (upCnt != 2'd0) |->
        (aDriveEn[h*HALF_W +: HALF_W] == {HALF_W{~$past(pathEnBaN[h]) & ~$past(outEnBaN[h])}}));

    assert_transparent_b_R4: assert property (@(posedge clk) disable iff (!rstN)
      (upCnt != 2'd0 && !$past(pathEnAbN[h]) && !$past(latchEnAbN[h])) |->
        (bOut[h*HALF_W +: HALF_W] == $past(aIn[h*HALF_W +: HALF_W])));

    assert_transparent_a_R8: assert property (@(posedge clk) disable iff (!rstN)
      (upCnt != 2'd0 && !$past(pathEnBaN[h]) && !$past(latchEnBaN[h])) |->
        (aOut[h*HALF_W +: HALF_W] == $past(bIn[h*HALF_W +: HALF_W])));

    // Closed for two edges in a row: shown value must not move (R5, R6)
    assert_hold_b_R6: assert property (@(posedge clk) disable iff (!rstN)
      (upCnt >= 2'd2 && ($past(pathEnAbN[h]) || $past(latchEnAbN[h]))
                     && ($past(pathEnAbN[h], 2) || $past(latchEnAbN[h], 2))) |->
        $stable(bOut[h*HALF_W +: HALF_W]));

    assert_hold_a_R8: assert property (@(posedge clk) disable iff (!rstN)
      (upCnt >= 2'd2 && ($past(pathEnBaN[h]) || $past(latchEnBaN[h]))
                     && ($past(pathEnBaN[h], 2) || $past(latchEnBaN[h], 2))) |->
        $stable(aOut[h*HALF_W +: HALF_W]));

    assert_contention_R10: assert property (@(posedge clk) disable iff (!rstN)
      contention[h] == (aDriveEn[h*HALF_W] & bDriveEn[h*HALF_W]));
  end
endmodule

bind latched_bus_xcvr bxcvr_checker #(.HALF_W(HALF_W), .NUM_HALVES(NUM_HALVES)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .aIn        (aIn),
  .bIn        (bIn),
  .pathEnAbN  (pathEnAbN),
  .latchEnAbN (latchEnAbN),
  .outEnAbN   (outEnAbN),
  .pathEnBaN  (pathEnBaN),
  .latchEnBaN (latchEnBaN),
  .outEnBaN   (outEnBaN),
  .aOut       (aOut),
  .aDriveEn   (aDriveEn),
  .bOut       (bOut),
  .bDriveEn   (bDriveEn),
  .contention (contention)
);

// File: tb/latched_bus_xcvr_test.sv
module latched_bus_xcvr_test;
  localparam int HW = 8;
  localparam int NH = 2;
  localparam int BW = HW * NH;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [BW-1:0] aIn = '0, bIn = '0;
  logic [NH-1:0] pathEnAbN = '1, latchEnAbN = '1, outEnAbN = '1;
  logic [NH-1:0] pathEnBaN = '1, latchEnBaN = '1, outEnBaN = '1;
  logic [BW-1:0] aOut, aDriveEn, bOut, bDriveEn;
  logic [NH-1:0] contention;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5ns clk = ~clk;

  latched_bus_xcvr uut (
    .clk(clk), .rstN(rstN), .aIn(aIn), .bIn(bIn),
    .pathEnAbN(pathEnAbN), .latchEnAbN(latchEnAbN), .outEnAbN(outEnAbN),
    .pathEnBaN(pathEnBaN), .latchEnBaN(latchEnBaN), .outEnBaN(outEnBaN),
    .aOut(aOut), .aDriveEn(aDriveEn), .bOut(bOut), .bDriveEn(bDriveEn),
    .contention(contention)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic idle();
    pathEnAbN = '1; latchEnAbN = '1; outEnAbN = '1;
    pathEnBaN = '1; latchEnBaN = '1; outEnBaN = '1;
  endtask

  task automatic setCtl(input int dir, input int h, input logic ce, input logic le, input logic oe);
    if (dir == 0) begin
      pathEnAbN[h] = ce; latchEnAbN[h] = le; outEnAbN[h] = oe;
    end else begin
      pathEnBaN[h] = ce; latchEnBaN[h] = le; outEnBaN[h] = oe;
    end
  endtask

  task automatic setData(input int dir, input int h, input logic [HW-1:0] v);
    if (dir == 0) aIn[h*HW +: HW] = v;
    else          bIn[h*HW +: HW] = v;
  endtask

  function automatic logic [HW-1:0] getOut(input int dir, input int h);
    return (dir == 0) ? bOut[h*HW +: HW] : aOut[h*HW +: HW];
  endfunction

  function automatic logic [HW-1:0] getDrv(input int dir, input int h);
    return (dir == 0) ? bDriveEn[h*HW +: HW] : aDriveEn[h*HW +: HW];
  endfunction

  // R1: idle after reset, storage empty
  task automatic testReset();
    check("R1 bDriveEn", bDriveEn, 0);
    check("R1 aDriveEn", aDriveEn, 0);
    check("R1 contention", contention, 0);
    aIn = 16'hA5A5; bIn = 16'h5A5A;
    for (int h = 0; h < NH; h++) begin
      setCtl(0, h, 1'b0, 1'b1, 1'b0);
      setCtl(1, h, 1'b0, 1'b1, 1'b0);
    end
    step();
    check("R1 bOut storage", bOut, 0);
    check("R1 aOut storage", aOut, 0);
    check("R10 both drive", contention, 2'b11);
    check("R10 bDriveEn still on", bDriveEn, 16'hFFFF);
    check("R10 aDriveEn still on", aDriveEn, 16'hFFFF);
    idle();
    step();
  endtask

  // R2: one edge to the outputs, steady between edges
  task automatic testLatency();
    setCtl(0, 0, 1'b0, 1'b0, 1'b0);
    aIn[7:0] = 8'h5A;
    step();
    check("R2 first value", bOut[7:0], 8'h5A);
    aIn[7:0] = 8'h3C;
    #1ns;
    check("R2 no change before edge", bOut[7:0], 8'h5A);
    step();
    check("R2 after edge", bOut[7:0], 8'h3C);
    idle();
    step();
  endtask

  // Sweep all control combinations for one direction of one half
  task automatic testTruthTable(input int dir, input int h);
    string tDrv, tData, tHold, tProbe;
    tDrv   = (dir == 0) ? "R3 drive"       : "R8 drive";
    tData  = (dir == 0) ? "R4 transparent" : "R8 transparent";
    tHold  = (dir == 0) ? "R5 holding"     : "R8 holding";
    tProbe = (dir == 0) ? "R6/R7 stored"   : "R8 stored";
    for (int combo = 0; combo < 8; combo++) begin
      logic ce, le, oe;
      logic [HW-1:0] v1, v2, v3;
      ce = combo[2]; le = combo[1]; oe = combo[0];
      v1 = 8'h30 + 8'(combo);
      v2 = 8'hC0 + 8'(combo);
      v3 = 8'h77;
      // preload v1 and close the latch
      setData(dir, h, v1);
      setCtl(dir, h, 1'b0, 1'b0, 1'b1);
      step();
      setCtl(dir, h, 1'b0, 1'b1, 1'b1);
      setData(dir, h, 8'hEE);
      step();
      // apply the combination under test
      setData(dir, h, v2);
      setCtl(dir, h, ce, le, oe);
      step();
      check(tDrv, getDrv(dir, h), (!ce && !oe) ? 8'hFF : 8'h00);
      if (!ce && !oe) check((!le) ? tData : tHold, getOut(dir, h), (!le) ? v2 : v1);
      // probe what the storage kept
      setData(dir, h, v3);
      setCtl(dir, h, 1'b0, 1'b1, 1'b0);
      step();
      check(tProbe, getOut(dir, h), (!ce && !le) ? v2 : v1);
      idle();
      step();
    end
  endtask

  // R5: rising latch enable keeps the last transparent value
  task automatic testCapture();
    setCtl(0, 1, 1'b0, 1'b0, 1'b0);
    aIn[15:8] = 8'h11; step();
    aIn[15:8] = 8'h22; step();
    aIn[15:8] = 8'h33; step();
    check("R5 transparent before capture", bOut[15:8], 8'h33);
    latchEnAbN[1] = 1'b1;
    aIn[15:8] = 8'h44; step();
    check("R5 captured", bOut[15:8], 8'h33);
    aIn[15:8] = 8'h55; step();
    aIn[15:8] = 8'h66; step();
    check("R5 input ignored while held", bOut[15:8], 8'h33);
    idle();
    step();
  endtask

  // R9/R11: half 0 unaffected by half 1 activity, byte placement
  task automatic testIndependence();
    setCtl(0, 0, 1'b0, 1'b0, 1'b0);
    aIn = 16'h00AA; step();
    latchEnAbN[0] = 1'b1;
    aIn = 16'h0000; step();
    for (int i = 0; i < 4; i++) begin
      logic [HW-1:0] hv;
      hv = 8'h90 + 8'(i);
      aIn = {hv, 8'(8'h10 * i)};
      setCtl(0, 1, 1'b0, 1'b0, 1'b0);
      setCtl(1, 1, 1'(i), 1'b0, 1'b0);
      step();
      check("R9 half0 data", bOut[7:0], 8'hAA);
      check("R9 half0 drive", bDriveEn[7:0], 8'hFF);
      check("R9 half0 A side idle", aDriveEn[7:0], 8'h00);
      check("R11 word placement", bOut, {hv, 8'hAA});
    end
    idle();
    step();
  endtask

  // R10: flag per half only where both directions drive
  task automatic testContention();
    setCtl(0, 0, 1'b0, 1'b1, 1'b0);
    setCtl(0, 1, 1'b0, 1'b1, 1'b0);
    setCtl(1, 1, 1'b0, 1'b1, 1'b0);
    step();
    check("R10 flag half1 only", contention, 2'b10);
    check("R10 bDriveEn", bDriveEn, 16'hFFFF);
    check("R10 aDriveEn", aDriveEn, 16'hFF00);
    idle();
    step();
    check("R10 flag clears", contention, 2'b00);
  endtask

  initial begin
    #500us;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    step();
    testReset();
    testLatency();
    for (int d = 0; d < 2; d++)
      for (int h = 0; h < NH; h++)
        testTruthTable(d, h);
    testCapture();
    testIndependence();
    testContention();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule